// File: doc/BRIEF.md
# Pulse-Distributed PWM D/A Generator

This block turns a 14-bit code into a single-bit waveform whose average level, after an external low-pass filter, represents that code. One conversion cycle is 16384 resolution ticks long. Rather than one long pulse per cycle, the cycle is cut into many short base cycles, so the ripple sits at a much higher frequency and is easier to filter.

A frame-size select picks 256 base cycles of 64 ticks or 64 base cycles of 256 ticks. Each base cycle opens with an active pulse. The pulse is the code divided by the number of base cycles, and selected base cycles get one extra tick. A polarity select chooses whether the active level is low or high. A write port loads the code. The code and both selects are copied into working copies only when a conversion cycle wraps, so the waveform never changes partway through a cycle. A clock-select input sets the tick rate: either every asserted tick enable, or every second one.

Top module: `pwm_dac14`

## Requirements
- R1: A 14-bit tick counter runs from 0 to 16383 and wraps to 0. One conversion cycle is 16384 ticks.
- R2: With polarity 0 the active level is low. If the working code V is at least the number of base cycles, the output is low for exactly V ticks in each conversion cycle.
- R3: Let m be the number of base cycles: 256 when frame_sel is 0 and 64 when it is 1. Each base cycle is 16384/m ticks. In base cycle i the output is active for the first floor(V/m) ticks. It is active for one extra tick when the bit-reversed i is less than V mod m. The reversal uses log2(m) bits.
- R4: With polarity 1 the active level is high. The output is high for exactly V ticks in each conversion cycle, provided V is at least m.
- R5: When V is less than m (less than 256 with frame_sel 0, less than 64 with frame_sel 1), the output stays at the inactive level for the whole conversion cycle.
- R6: When the low log2(m) bits of V are zero, every base cycle carries the same pulse, so the waveform repeats with the base-cycle period.
- R7: A code written with wr_en, and the values on frame_sel and invert, take effect together. They are captured on the tick that wraps the counter from 16383 to 0. Until then the running conversion cycle is unchanged.
- R8: With clk_sel 0, every clock with tick_en high advances the counter. With clk_sel 1, only every second clock with tick_en high advances it. The first such clock after reset does not advance it, the second does, and so on.
- R9: Reset clears the code and its working copy and sets both selects to 0. The output is then high, which is the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Resolution tick enable |
| clk_sel | input | 1 | 0: each enable is a tick; 1: every second enable |
| frame_sel | input | 1 | 0: 256 base cycles of 64 ticks; 1: 64 of 256 |
| invert | input | 1 | 0: active low; 1: active high |
| wr_en | input | 1 | Write strobe for the code |
| wr_data | input | 14 | Code to load |
| pwm_out | output | 1 | PWM output |

## Verification
If the tick counter holds a wrong value, an edge of pwm_out moves within one base cycle, which is at most 256 ticks. A reference model that steps through the same ticks detects the first mismatching clock. A working copy of the code loaded at the wrong time shows up as a wrong sum of active ticks over the affected conversion cycle. A fault in the bit reversal moves the extra ticks to different base cycles while leaving the sum correct, so only a clock-by-clock comparison finds it. A wrong clock-select phase moves every edge after the first skipped enable.

// File: rtl/pwm_dac14.sv
module pwm_dac14 #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          clk_sel,
  input  logic          frame_sel,
  input  logic          invert,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_out
);
  localparam int FI = DW - 6;   // index bits, short base cycles
  localparam int CI = DW - 8;   // index bits, long base cycles
  localparam int FP = DW - FI;  // position bits, short base cycles
  localparam int CP = DW - CI;  // position bits, long base cycles

  logic [DW-1:0] dreg, shd, cnt;
  logic          cfs_s, os_s, ph;
  logic [FI-1:0] idx, rev, rem;
  logic [CP-1:0] pos;
  logic [CP:0]   upper, width;
  logic          active;

  wire tick = tick_en && (!clk_sel || ph);
  wire wrap = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg  <= '0;
      shd   <= '0;
      cnt   <= '0;
      cfs_s <= 1'b0;
      os_s  <= 1'b0;
      ph    <= 1'b0;
    end else begin
      if (wr_en) dreg <= wr_data;
      if (tick_en && clk_sel) ph <= ~ph;
      if (tick) cnt <= cnt + 1'b1;
      if (wrap) begin
        shd   <= dreg;
        cfs_s <= frame_sel;
        os_s  <= invert;
      end
    end
  end

  always_comb begin
    rev = '0;
    if (!cfs_s) begin
      idx   = cnt[DW-1 -: FI];
      pos   = CP'(cnt[FP-1:0]);
      upper = (CP+1)'(shd[DW-1:FI]);
      rem   = shd[FI-1:0];
      for (int k = 0; k < FI; k++) rev[k] = idx[FI-1-k];
    end else begin
      idx   = FI'(cnt[DW-1 -: CI]);
      pos   = cnt[CP-1:0];
      upper = (CP+1)'(shd[DW-1:CI]);
      rem   = FI'(shd[CI-1:0]);
      for (int k = 0; k < CI; k++) rev[k] = idx[CI-1-k];
    end
    width  = upper + {{CP{1'b0}}, (rev < rem)};
    active = (upper != '0) && ({1'b0, pos} < width);
  end

  assign pwm_out = active ~^ os_s;
endmodule

// File: rtl/pwm_dac14_chk.sv
module pwm_dac14_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          clk_sel,
  input logic          pwm_out,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] shd,
  input logic [DW-1:0] dreg,
  input logic          cfs_s,
  input logic          os_s,
  input logic          ph
);
  wire at_end = tick_en && (!clk_sel || ph) && (cnt == '1);

  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pwm_out && shd == '0 && dreg == '0 && !cfs_s && !os_s));

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> cnt == '0);

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> ($stable(shd) && $stable(cfs_s) && $stable(os_s)));

  a_r7_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> shd == $past(dreg));

  a_r8_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel && tick_en && !ph) |=> $stable(cnt));

  a_r5_flat: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfs_s && shd < 64) || (!cfs_s && shd < 256)) |-> pwm_out == !os_s);
endmodule

bind pwm_dac14 pwm_dac14_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel),
  .pwm_out(pwm_out), .cnt(cnt), .shd(shd), .dreg(dreg),
  .cfs_s(cfs_s), .os_s(os_s), .ph(ph)
);

// File: tb/sim_pwm_dac14.sv
`timescale 1ns/1ps
module sim_pwm_dac14;
  logic clk = 0, rst_n = 0, tick_en = 0, clk_sel = 0;
  logic frame_sel = 0, invert = 0, wr_en = 0;
  logic [13:0] wr_data = '0;
  logic pwm_out;
  int total = 0, bad = 0;
  bit cmp_on = 0;
  string ctag = "R3";

  int m_cnt = 0, m_pend = 0, m_shd = 0, m_en = 0;
  bit m_cfs = 0, m_os = 0;

  pwm_dac14 u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel),
                .frame_sel(frame_sel), .invert(invert), .wr_en(wr_en),
                .wr_data(wr_data), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit exp_out(int c, int v, bit cf, bit o);
    int m, bl, nb, i, p, up, rm, r;
    bit act;
    m = cf ? 64 : 256;
    nb = cf ? 6 : 8;
    bl = 16384 / m;
    i = c / bl; p = c % bl;
    up = v / m; rm = v % m; r = 0;
    for (int k = 0; k < nb; k++)
      if (((i >> k) & 1) != 0) r = r | (1 << (nb - 1 - k));
    act = (up != 0) && (p < up + ((r < rm) ? 1 : 0));
    return act ? o : !o;
  endfunction

  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_shd = 0; m_en = 0; m_cfs = 0; m_os = 0;
    end else begin
      tk = 0;
      if (tick_en) begin
        if (!clk_sel) tk = 1;
        else begin
          m_en++;
          if (m_en % 2 == 0) tk = 1;
        end
      end
      if (tk) begin
        if (m_cnt == 16383) begin
          m_cnt = 0; m_shd = m_pend; m_cfs = frame_sel; m_os = invert;
        end else m_cnt++;
      end
      if (wr_en) m_pend = int'(wr_data);
    end
  end

  always @(negedge clk)
    if (rst_n && cmp_on)
      chk(pwm_out == exp_out(m_cnt, m_shd, m_cfs, m_os), ctag,
          int'(pwm_out), int'(exp_out(m_cnt, m_shd, m_cfs, m_os)));

  task automatic frame(int expv, int nv, bit ncfs, bit nos, string tag, bit per);
    int cntact;
    bit hist [64];
    cntact = 0;
    ctag = tag;
    for (int t = 0; t < 16384; t++) begin
      if (pwm_out == m_os) cntact++;
      if (per) begin
        if (t >= 64) chk(pwm_out == hist[t % 64], "R6 period", int'(pwm_out), int'(hist[t % 64]));
        hist[t % 64] = pwm_out;
      end
      if (t == 8000) begin
        wr_en = 1; wr_data = 14'(nv); frame_sel = ncfs; invert = nos;
      end
      if (t == 8001) wr_en = 0;
      @(negedge clk);
    end
    chk(cntact == expv, {tag, " active sum, R7 held"}, cntact, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b1, "R9 reset level", int'(pwm_out), 1);
    rst_n = 1; cmp_on = 1; tick_en = 1;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R9 idle after reset", int'(pwm_out), 1);
    wr_en = 1; wr_data = 14'd1000;
    @(negedge clk);
    wr_en = 0;
    while (m_cnt != 0) @(negedge clk);
    frame(1000,  1000, 1, 1, "R2", 0);
    frame(1000,  100,  0, 0, "R4", 0);
    frame(0,     100,  1, 0, "R5", 0);
    frame(100,   16383,0, 0, "R5", 0);
    frame(16383, 3072, 0, 0, "R2", 0);
    frame(3072,  5,    0, 1, "R3", 1);
    frame(0,     2000, 1, 0, "R5", 0);
    ctag = "R8";
    clk_sel = 1;
    for (int n = 0; n < 20000; n++) begin
      tick_en = ($urandom % 3) != 0;
      @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule